// File: doc/BRIEF.md
# Direct-Window Address Translator

This block is the first stage of a virtual-to-physical address translation path. Each accepted request carries a virtual address, the requester's privilege (kernel or user), two mode bits that select direct addressing or paging, and a flag that picks 64-bit or 32-bit addressing. The block first checks for direct addressing. It then compares the address against four direct-map window registers. If no window claims the address, it checks that the address is canonical.

Every request ends in exactly one of three outcomes, reported one clock after it is accepted. A request can be resolved, in which case a physical address and read, write and execute permissions are given. It can be forwarded to the page-table lookup stage that follows. Or it can be rejected with a bad-address fault. Windows are searched from index 0 upward, and the lowest matching window wins. In 32-bit mode a window also swaps the top segment of the address for a physical segment of its own.

Top module: `dmw_xlate_top`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, until a request is accepted, `out_valid`, `resolved`, `fwd_tlb`, `bad_addr`, the three permission bits and `paddr` are all 0.
- R2: A request accepted with `in_valid` high at an edge is answered at the next edge with `out_valid` high and exactly one of `resolved`, `fwd_tlb` and `bad_addr` high. When `out_valid` is low, all three are low.
- R3: When `da`=1 and `pg`=0, the request is resolved with `paddr` equal to `vaddr[47:0]` zero-extended and all three permissions set. This holds whatever the window registers contain.
- R4: Any other combination of `da` and `pg` is handled by the window search and the canonical check.
- R5: A window takes part in the search only if it is enabled for the requester's privilege. Bit 0 of the window word enables kernel requests (`priv_user`=0), and bit 3 enables user requests (`priv_user`=1).
- R6: In 64-bit mode (`mode64`=1), an enabled window matches when its bits [63:60] equal `vaddr[63:60]`. The result is `vaddr[47:0]` zero-extended to 64 bits.
- R7: In 32-bit mode, an enabled window matches when its bits [31:29] equal `vaddr[31:29]`. The result has bits [63:32] at 0, bits [31:29] taken from window bits [27:25], and bits [28:0] taken from `vaddr[28:0]`.
- R8: When several enabled windows match, the one with the lowest index supplies the result.
- R9: Every resolved request, whether direct or through a window, grants read, write and execute.
- R10: A request that neither direct mode nor a window resolves, and whose `vaddr[63:48]` is all zeros or all ones, raises `fwd_tlb`. In that case `paddr` and the permissions are 0.
- R11: A request that is not resolved and whose `vaddr[63:48]` is neither all zeros nor all ones raises `bad_addr`. A window match takes precedence over this check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| vaddr | input | 64 | Virtual address |
| priv_user | input | 1 | 1 = user request, 0 = kernel request |
| da | input | 1 | Direct-address mode bit |
| pg | input | 1 | Paging mode bit |
| mode64 | input | 1 | 1 = 64-bit addressing, 0 = 32-bit |
| win_cfg | input | 256 | Four window words, window i at bits [64*i+63:64*i] |
| out_valid | output | 1 | Result present |
| resolved | output | 1 | Address translated by direct mode or a window |
| fwd_tlb | output | 1 | Canonical and unresolved, so handed to the next stage |
| bad_addr | output | 1 | Non-canonical address fault |
| paddr | output | 64 | Physical address, 0 unless resolved |
| perm_r | output | 1 | Read permitted |
| perm_w | output | 1 | Write permitted |
| perm_x | output | 1 | Execute permitted |

## Verification
Every result is due on the first rising edge after the edge that accepts the request. No result is spread over several cycles. The bench drives each request on a falling edge and waits one rising edge. It then compares all outputs on the following falling edge against a value computed from the rules above, so each comparison sits half a cycle away from any register update. Idle cycles and the reset state are sampled in the same way.

// File: rtl/dmw_pkg.sv
package dmw_pkg;
  // Bit positions of the privilege enables in a window word
  localparam int KEN_BIT = 0;
  localparam int UEN_BIT = 3;

  typedef enum logic [1:0] {
    OUT_NONE     = 2'd0,
    OUT_RESOLVED = 2'd1,
    OUT_FORWARD  = 2'd2,
    OUT_BADADDR  = 2'd3
  } outcome_e;
endpackage

// File: rtl/dmw_win_match.sv
module dmw_win_match
  import dmw_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int VIRT_W    = 48,
  parameter int SEG64_LO  = 60,
  parameter int SEG32_LO  = 29,
  parameter int PSEG32_LO = 25
) (
  input  logic [ADDR_W-1:0] win,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              priv_user,
  input  logic              mode64,
  output logic              hit,
  output logic [ADDR_W-1:0] pa
);
  localparam int SEG32_W = 32 - SEG32_LO;
  localparam int ZW64    = ADDR_W - VIRT_W;
  localparam int ZW32    = ADDR_W - 32;

  logic enabled;
  logic tag64_eq;
  logic tag32_eq;
  logic [ADDR_W-1:0] pa64;
  logic [ADDR_W-1:0] pa32;

  always_comb begin
    enabled  = priv_user ? win[UEN_BIT] : win[KEN_BIT];
    tag64_eq = (win[ADDR_W-1:SEG64_LO] == vaddr[ADDR_W-1:SEG64_LO]);
    tag32_eq = (win[31:SEG32_LO] == vaddr[31:SEG32_LO]);
    pa64     = {{ZW64{1'b0}}, vaddr[VIRT_W-1:0]};
    pa32     = {{ZW32{1'b0}}, win[PSEG32_LO+SEG32_W-1:PSEG32_LO], vaddr[SEG32_LO-1:0]};
    hit      = enabled & (mode64 ? tag64_eq : tag32_eq);
    pa       = mode64 ? pa64 : pa32;
  end
endmodule

// File: rtl/dmw_prio_select.sv
module dmw_prio_select #(
  parameter int NUM_WIN = 4,
  parameter int ADDR_W  = 64
) (
  input  logic [NUM_WIN-1:0]        hits,
  input  logic [NUM_WIN*ADDR_W-1:0] pas,
  output logic                      any_hit,
  output logic [ADDR_W-1:0]         pa
);
  // Walk from the top index down so the lowest hitting index is written last
  always_comb begin
    any_hit = 1'b0;
    pa      = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any_hit = 1'b1;
        pa      = pas[i*ADDR_W +: ADDR_W];
      end
    end
  end
endmodule

// File: rtl/dmw_canon_check.sv
module dmw_canon_check #(
  parameter int ADDR_W = 64,
  parameter int VIRT_W = 48
) (
  input  logic [ADDR_W-1:0] vaddr,
  output logic              canonical
);
  localparam int HI_W = ADDR_W - VIRT_W;

  logic [HI_W-1:0] upper;

  always_comb begin
    upper     = vaddr[ADDR_W-1:VIRT_W];
    canonical = (&upper) | ~(|upper);
  end
endmodule

// File: rtl/dmw_xlate_top.sv
module dmw_xlate_top
  import dmw_pkg::*;
#(
  parameter int NUM_WIN   = 4,
  parameter int ADDR_W    = 64,
  parameter int VIRT_W    = 48,
  parameter int PHYS_W    = 48,
  parameter int SEG64_LO  = 60,
  parameter int SEG32_LO  = 29,
  parameter int PSEG32_LO = 25
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [ADDR_W-1:0]         vaddr,
  input  logic                      priv_user,
  input  logic                      da,
  input  logic                      pg,
  input  logic                      mode64,
  input  logic [NUM_WIN*ADDR_W-1:0] win_cfg,
  output logic                      out_valid,
  output logic                      resolved,
  output logic                      fwd_tlb,
  output logic                      bad_addr,
  output logic [ADDR_W-1:0]         paddr,
  output logic                      perm_r,
  output logic                      perm_w,
  output logic                      perm_x
);
  localparam int PZW = ADDR_W - PHYS_W;

  logic [NUM_WIN-1:0]        win_hit;
  logic [NUM_WIN*ADDR_W-1:0] win_pa;
  logic                      any_win;
  logic [ADDR_W-1:0]         sel_pa;
  logic                      canonical;
  logic                      direct;
  outcome_e                  outcome_d;
  logic [ADDR_W-1:0]         pa_d;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    dmw_win_match #(
      .ADDR_W   (ADDR_W),
      .VIRT_W   (VIRT_W),
      .SEG64_LO (SEG64_LO),
      .SEG32_LO (SEG32_LO),
      .PSEG32_LO(PSEG32_LO)
    ) win_i (
      .win      (win_cfg[g*ADDR_W +: ADDR_W]),
      .vaddr    (vaddr),
      .priv_user(priv_user),
      .mode64   (mode64),
      .hit      (win_hit[g]),
      .pa       (win_pa[g*ADDR_W +: ADDR_W])
    );
  end

  dmw_prio_select #(
    .NUM_WIN(NUM_WIN),
    .ADDR_W (ADDR_W)
  ) prio_i (
    .hits   (win_hit),
    .pas    (win_pa),
    .any_hit(any_win),
    .pa     (sel_pa)
  );

  dmw_canon_check #(
    .ADDR_W(ADDR_W),
    .VIRT_W(VIRT_W)
  ) canon_i (
    .vaddr    (vaddr),
    .canonical(canonical)
  );

  // Decision order: direct mode, then windows, then canonical check
  always_comb begin
    direct = da & ~pg;
    pa_d   = '0;
    if (!in_valid) begin
      outcome_d = OUT_NONE;
    end else if (direct) begin
      outcome_d = OUT_RESOLVED;
      pa_d      = {{PZW{1'b0}}, vaddr[PHYS_W-1:0]};
    end else if (any_win) begin
      outcome_d = OUT_RESOLVED;
      pa_d      = sel_pa;
    end else if (canonical) begin
      outcome_d = OUT_FORWARD;
    end else begin
      outcome_d = OUT_BADADDR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      resolved  <= 1'b0;
      fwd_tlb   <= 1'b0;
      bad_addr  <= 1'b0;
      paddr     <= '0;
      perm_r    <= 1'b0;
      perm_w    <= 1'b0;
      perm_x    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      resolved  <= (outcome_d == OUT_RESOLVED);
      fwd_tlb   <= (outcome_d == OUT_FORWARD);
      bad_addr  <= (outcome_d == OUT_BADADDR);
      paddr     <= pa_d;
      perm_r    <= (outcome_d == OUT_RESOLVED);
      perm_w    <= (outcome_d == OUT_RESOLVED);
      perm_x    <= (outcome_d == OUT_RESOLVED);
    end
  end

  // Exactly one outcome per answered request
  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot({resolved, fwd_tlb, bad_addr}));

  // No outcome flag without a request
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !resolved && !fwd_tlb && !bad_addr);

  // Direct mode passes the physical bits through with full rights
  assert_direct_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(da && !pg)) |->
      (resolved && perm_r && perm_w && perm_x &&
       paddr == {{PZW{1'b0}}, $past(vaddr[PHYS_W-1:0])}));

  // Any resolution grants all rights
  assert_full_rights_R9: assert property (@(posedge clk) disable iff (rst)
    resolved |-> perm_r && perm_w && perm_x);

  // Unresolved results carry no address and no rights
  assert_unresolved_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !resolved) |-> (paddr == '0) && !perm_r && !perm_w && !perm_x);

  // A fault only for a non-canonical upper field
  assert_bad_noncanon_R11: assert property (@(posedge clk) disable iff (rst)
    bad_addr |-> !($past(&vaddr[ADDR_W-1:VIRT_W]) || $past(~|vaddr[ADDR_W-1:VIRT_W])));
endmodule

// File: tb/dmw_xlate_top_tb.sv
`timescale 1ns/1ps
module dmw_xlate_top_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [63:0]  vaddr;
  logic         priv_user;
  logic         da;
  logic         pg;
  logic         mode64;
  logic [255:0] win_cfg;
  logic         out_valid, resolved, fwd_tlb, bad_addr;
  logic [63:0]  paddr;
  logic         perm_r, perm_w, perm_x;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  dmw_xlate_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .vaddr(vaddr),
    .priv_user(priv_user), .da(da), .pg(pg), .mode64(mode64),
    .win_cfg(win_cfg), .out_valid(out_valid), .resolved(resolved),
    .fwd_tlb(fwd_tlb), .bad_addr(bad_addr), .paddr(paddr),
    .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
  );

  function automatic logic [63:0] mk_win(input bit ken, input bit uen,
                                         input logic [3:0] s64, input logic [2:0] s32,
                                         input logic [2:0] ps);
    logic [63:0] w = 64'h0;
    w[63:60] = s64;
    w[31:29] = s32;
    w[27:25] = ps;
    w[10]    = 1'b1;
    w[0]     = ken;
    w[3]     = uen;
    return w;
  endfunction

  // Expected {resolved, fwd, bad, r, w, x, paddr}
  function automatic logic [69:0] model(input logic [63:0] va, input bit usr,
                                        input bit d, input bit p, input bit m64,
                                        input logic [255:0] wc, output string tag);
    logic [63:0] w;
    bit en;
    if (d && !p) begin
      tag = "R3";
      return {3'b100, 3'b111, 16'h0, va[47:0]};
    end
    for (int i = 0; i < 4; i++) begin
      w  = wc[i*64 +: 64];
      en = usr ? w[3] : w[0];
      if (en && m64 && w[63:60] == va[63:60]) begin
        tag = "R6";
        return {3'b100, 3'b111, 16'h0, va[47:0]};
      end
      if (en && !m64 && w[31:29] == va[31:29]) begin
        tag = "R7";
        return {3'b100, 3'b111, 32'h0, w[27:25], va[28:0]};
      end
    end
    if (va[63:48] == 16'h0 || va[63:48] == 16'hFFFF) begin
      tag = "R10";
      return {3'b010, 3'b000, 64'h0};
    end
    tag = "R11";
    return {3'b001, 3'b000, 64'h0};
  endfunction

  task automatic compare(input string tag, input logic [69:0] exp);
    logic [69:0] act = {resolved, fwd_tlb, bad_addr, perm_r, perm_w, perm_x, paddr};
    checks++;
    if (act !== exp || out_valid !== 1'b1) begin
      failures++;
      $display("FAIL %s va=%h act=%h valid=%b exp=%h", tag, vaddr, act, out_valid, exp);
    end
  endtask

  // Called on a falling edge: drive, wait one rising edge, sample on the next falling edge
  task automatic run_one(input logic [63:0] va, input bit usr, input bit d,
                         input bit p, input bit m64, input logic [255:0] wc,
                         input string force_tag);
    string tag;
    logic [69:0] exp;
    in_valid = 1'b1; vaddr = va; priv_user = usr; da = d; pg = p;
    mode64 = m64; win_cfg = wc;
    exp = model(va, usr, d, p, m64, wc, tag);
    @(posedge clk);
    @(negedge clk);
    if (force_tag != "") tag = force_tag;
    compare(tag, exp);
  endtask

  initial begin
    logic [255:0] wc;
    logic [63:0]  va;
    logic [11:0]  mid;
    logic [3:0]   s;
    rst = 1'b1; in_valid = 1'b0; vaddr = 64'h0; priv_user = 1'b0;
    da = 1'b0; pg = 1'b1; mode64 = 1'b1; win_cfg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    // R1: reset state
    checks++;
    if ({out_valid, resolved, fwd_tlb, bad_addr, perm_r, perm_w, perm_x} !== 7'b0 ||
        paddr !== 64'h0) begin
      failures++;
      $display("FAIL R1 act=%b/%h exp=0/0",
               {out_valid, resolved, fwd_tlb, bad_addr, perm_r, perm_w, perm_x}, paddr);
    end

    // R8: windows 0 and 2 both match in 32-bit mode; window 0's segment 3'b101 wins
    wc = '0;
    wc[0*64 +: 64] = mk_win(1, 1, 4'h0, 3'd2, 3'd5);
    wc[2*64 +: 64] = mk_win(1, 1, 4'h0, 3'd2, 3'd6);
    run_one({32'hDEAD_BEEF, 3'd2, 29'h0123_4567}, 0, 0, 1, 0, wc, "R8");
    checks++;
    if (paddr[31:29] !== 3'd5) begin
      failures++;
      $display("FAIL R8 act=%0d exp=5", paddr[31:29]);
    end
    // R5: window 0 kernel-disabled, so window 2 applies to kernel
    wc[0*64 +: 64] = mk_win(0, 1, 4'h0, 3'd2, 3'd5);
    run_one({32'hDEAD_BEEF, 3'd2, 29'h0123_4567}, 0, 0, 1, 0, wc, "R5");
    checks++;
    if (paddr[31:29] !== 3'd6) begin
      failures++;
      $display("FAIL R5 act=%0d exp=6", paddr[31:29]);
    end
    // R5: user enable only, kernel request falls through to the canonical check (R10)
    wc = '0;
    wc[64 +: 64] = mk_win(0, 1, 4'h0, 3'd0, 3'd1);
    run_one(64'h0000_1234_0000_0010, 0, 0, 1, 1, wc, "R5");
    // R4: da=1 with pg=1 uses windows; noncanonical address with matching window resolves (R11 precedence)
    wc[64 +: 64] = mk_win(1, 0, 4'h9, 3'd0, 3'd1);
    run_one(64'h9123_4567_89AB_CDEF, 0, 1, 1, 1, wc, "R4");
    // R2: idle cycle gives no outcome
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if ({out_valid, resolved, fwd_tlb, bad_addr} !== 4'b0) begin
      failures++;
      $display("FAIL R2 act=%b exp=0000", {out_valid, resolved, fwd_tlb, bad_addr});
    end

    // Sweep: configurations, segments, upper patterns, privilege, mode bits, width mode (R3 R6 R7 R9 R10 R11)
    for (int c = 0; c < 16; c++) begin
      for (int w = 0; w < 4; w++)
        wc[w*64 +: 64] = mk_win(((c + w) % 3) != 0, ((c + w) % 2) == 0,
                                4'((c * 3 + w * 5) % 16), 3'((c + w * 3) % 8),
                                3'((15 - w - c) % 8));
      for (int sv = 0; sv < 16; sv++) begin
        for (int v = 0; v < 3; v++) begin
          s   = 4'(sv);
          mid = (v == 0) ? 12'h000 : (v == 1) ? 12'hFFF : 12'h5A5;
          va  = {s, mid, 16'hC3A5, s[2:0], 29'h0ABC_DEF1 ^ 29'(c)};
          for (int u = 0; u < 2; u++)
            for (int dp = 0; dp < 4; dp++)
              for (int m = 0; m < 2; m++)
                run_one(va, u[0], dp[1], dp[0], m[0], wc, "");
        end
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule